// File: doc/BRIEF.md
# SDRAM Open-Page Bank Tracker

This block keeps the page state of an SDRAM controller that leaves pages open between accesses. A table indexed by chip-select row and bank records, for each entry, whether a page is open and which page it is. Every incoming request is classified as a hit (its page is already open), a miss (another page is open in that bank) or an empty bank. The class then selects the command sequence put out on the command port: a lone read or write, precharge then activate then access, or activate then access. Activates open an entry and precharges close it. Nothing else closes a page. Pages therefore survive a change of bus master, and any number of entries may be open at once.

The request path has two stages. A lookup register holds the next request and classifies it against the table while the sequencer is still issuing the commands of the current request. The class is latched at the moment the sequencer takes the request over, so a back-to-back stream of hits gives one access per clock. Each row can be set to four banks or to two banks. A precharge-all strobe empties the whole table before refresh.

Top module: `open_page_tracker`

## Requirements
- R1: After reset every table entry is empty, `cmdValid` is 0 and `reqReady` is 1.
- R2: A request to an empty bank produces activate (cmdType 2) for exactly one cycle, followed in the next cycle by the access, with cmdStatus 0 (empty).
- R3: A request whose page is open in its bank produces only the access command, with cmdStatus 1 (hit).
- R4: A request to a bank holding a different open page produces precharge (cmdType 1), activate and access on three consecutive cycles, with cmdStatus 2 (miss).
- R5: The access command is read (cmdType 3) when `reqWrite` is 0 and write (cmdType 4) when it is 1. `cmdRow`, `cmdBank` and `cmdPage` carry the request's address for every command of its sequence.
- R6: An access leaves its page open. A later request to the same page from any source is a hit.
- R7: All row/bank entries (4 rows x 4 banks) can hold open pages at the same time, and each is tracked independently.
- R8: For a row whose `rowFourBank` bit is 0, bank bit 1 of the request is ignored: that row uses banks 0 and 1 only, and `cmdBank` bit 1 is 0.
- R9: A one-cycle `prechargeAll` pulse empties every entry, so the next request to a previously open page is classified empty.
- R10: Lookup overlaps the current sequence. Consecutive hits issue accesses on consecutive cycles. A request's class reflects the activate of the request issued just before it, so a same-bank different-page request that follows is a miss.
- R11: While the lookup stage holds a request that the sequencer cannot yet take, `reqReady` is 0 and the held request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high together with reqValid |
| reqRow | input | 2 | Chip-select row of the request |
| reqBank | input | 2 | Bank of the request |
| reqPage | input | 12 | Page (row address inside the bank) |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rowFourBank | input | 4 | Per row: 1 = four banks, 0 = two banks |
| prechargeAll | input | 1 | Empties every table entry |
| cmdValid | output | 1 | Command issued this cycle |
| cmdType | output | 3 | 1 precharge, 2 activate, 3 read, 4 write |
| cmdRow | output | 2 | Row of the command |
| cmdBank | output | 2 | Effective bank of the command |
| cmdPage | output | 12 | Page of the command |
| cmdStatus | output | 2 | Class of the request in service: 0 empty, 1 hit, 2 miss |

## Verification
The bench sends a request to the same bank with a new page right behind an activate. A design that classified it from the table before that activate landed would report empty and skip the precharge. It streams hits with no gaps and checks the access cycles: a lookup that does not overlap the sequence shows bubbles. It sends aliasing bank numbers to a two-bank row, which exposes a tracker that keeps bank bit 1 and reports empty where a hit is due. It also checks that precharge-all really empties every entry, since a stale valid bit would turn a required activate into a lone access to a closed page.

// File: rtl/otb_pkg.sv
package otb_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_PRE  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4
  } cmd_t;

  typedef enum logic [1:0] {
    PG_EMPTY = 2'd0,
    PG_HIT   = 2'd1,
    PG_MISS  = 2'd2
  } pageStatus_t;

  typedef enum logic [1:0] {
    STEP_PRE = 2'd0,
    STEP_ACT = 2'd1,
    STEP_ACC = 2'd2
  } seqStep_t;

  typedef struct packed {
    logic acceptA;
    logic moveAB;
    logic openPage;
    logic closePage;
  } otbStrobe_t;

endpackage

// File: rtl/otb_datapath.sv
module otb_datapath
  import otb_pkg::*;
#(
  parameter int NUM_ROWS  = 4,
  parameter int MAX_BANKS = 4,
  parameter int PAGE_W    = 12,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int BANK_W   = $clog2(MAX_BANKS),
  localparam int IDX_W    = ROW_W + BANK_W,
  localparam int NUM_ENT  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  otbStrobe_t        strobe,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              reqWrite,
  input  logic [NUM_ROWS-1:0] rowFourBank,
  input  logic              prechargeAll,
  output pageStatus_t       lookupStatus,
  output logic              bWrite,
  output logic [ROW_W-1:0]  bRow,
  output logic [BANK_W-1:0] bBank,
  output logic [PAGE_W-1:0] bPage
);

  logic [ROW_W-1:0]  aRow;
  logic [BANK_W-1:0] aBank;
  logic [PAGE_W-1:0] aPage;
  logic              aWrite;
  logic [BANK_W-1:0] reqBankEff;
  logic [IDX_W-1:0]  aIdx;
  logic [IDX_W-1:0]  bIdx;
  logic [NUM_ENT-1:0] entValid;
  logic [PAGE_W-1:0] entPage [NUM_ENT];
  logic              aEntValid;

  // two-bank rows keep only the low bank bit
  assign reqBankEff = rowFourBank[reqRow] ? reqBank : (reqBank & BANK_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aRow <= '0; aBank <= '0; aPage <= '0; aWrite <= 1'b0;
      bRow <= '0; bBank <= '0; bPage <= '0; bWrite <= 1'b0;
    end else begin
      if (strobe.moveAB) begin
        bRow <= aRow; bBank <= aBank; bPage <= aPage; bWrite <= aWrite;
      end
      if (strobe.acceptA) begin
        aRow <= reqRow; aBank <= reqBankEff; aPage <= reqPage; aWrite <= reqWrite;
      end
    end
  end

  assign aIdx = {aRow, aBank};
  assign bIdx = {bRow, bBank};

  generate
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entValid[e] <= 1'b0;
          entPage[e]  <= '0;
        end else if (prechargeAll) begin
          entValid[e] <= 1'b0;
        end else if (strobe.openPage && bIdx == IDX_W'(e)) begin
          entValid[e] <= 1'b1;
          entPage[e]  <= bPage;
        end else if (strobe.closePage && bIdx == IDX_W'(e)) begin
          entValid[e] <= 1'b0;
        end
      end
    end
  endgenerate

  assign aEntValid = entValid[aIdx] & ~prechargeAll;

  always_comb begin
    if (!aEntValid)                 lookupStatus = PG_EMPTY;
    else if (entPage[aIdx] == aPage) lookupStatus = PG_HIT;
    else                            lookupStatus = PG_MISS;
  end

  AST_OPEN_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.openPage && !prechargeAll |=> entValid[bIdx] && entPage[bIdx] == bPage); // R7

  AST_PREALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    prechargeAll |=> entValid == '0); // R9

  AST_TWO_BANK_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptA && !rowFourBank[reqRow] |=> aBank[BANK_W-1:1] == '0); // R8

endmodule

// File: rtl/otb_control.sv
module otb_control
  import otb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  pageStatus_t lookupStatus,
  input  logic        bWrite,
  output logic        reqReady,
  output otbStrobe_t  strobe,
  output logic        cmdValid,
  output cmd_t        cmdType,
  output pageStatus_t cmdStatus
);

  logic        aValid;
  logic        bValid;
  seqStep_t    bStep;
  logic        bDone;
  logic        moveAB;

  assign bDone    = bValid && bStep == STEP_ACC;
  assign moveAB   = aValid && (!bValid || bDone);
  assign reqReady = !aValid || moveAB;

  assign strobe.acceptA   = reqValid && reqReady;
  assign strobe.moveAB    = moveAB;
  assign strobe.openPage  = bValid && bStep == STEP_ACT;
  assign strobe.closePage = bValid && bStep == STEP_PRE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid    <= 1'b0;
      bValid    <= 1'b0;
      bStep     <= STEP_ACC;
      cmdStatus <= PG_EMPTY;
    end else begin
      if (strobe.acceptA)  aValid <= 1'b1;
      else if (moveAB)     aValid <= 1'b0;

      if (moveAB) begin
        bValid    <= 1'b1;
        cmdStatus <= lookupStatus;
        unique case (lookupStatus)
          PG_MISS: bStep <= STEP_PRE;
          PG_HIT:  bStep <= STEP_ACC;
          default: bStep <= STEP_ACT;
        endcase
      end else if (bDone) begin
        bValid <= 1'b0;
      end else if (bValid) begin
        bStep <= (bStep == STEP_PRE) ? STEP_ACT : STEP_ACC;
      end
    end
  end

  assign cmdValid = bValid;

  always_comb begin
    if (!bValid)                cmdType = CMD_NONE;
    else if (bStep == STEP_PRE) cmdType = CMD_PRE;
    else if (bStep == STEP_ACT) cmdType = CMD_ACT;
    else                        cmdType = bWrite ? CMD_WR : CMD_RD;
  end

  AST_PRE_THEN_ACT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdType == CMD_PRE |=> cmdValid && cmdType == CMD_ACT); // R4

  AST_ACT_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdType == CMD_ACT |=> cmdValid && (cmdType == CMD_RD || cmdType == CMD_WR)); // R2

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    moveAB && lookupStatus == PG_HIT |=> cmdType == CMD_RD || cmdType == CMD_WR); // R3

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    aValid && !moveAB |=> aValid && !reqReady == !moveAB); // R11

  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !bDone |=> cmdValid && $stable(cmdStatus)); // R10

endmodule

// File: rtl/open_page_tracker.sv
module open_page_tracker
  import otb_pkg::*;
#(
  parameter int NUM_ROWS  = 4,
  parameter int MAX_BANKS = 4,
  parameter int PAGE_W    = 12,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int BANK_W   = $clog2(MAX_BANKS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [PAGE_W-1:0]   reqPage,
  input  logic                reqWrite,
  input  logic [NUM_ROWS-1:0] rowFourBank,
  input  logic                prechargeAll,
  output logic                cmdValid,
  output logic [2:0]          cmdType,
  output logic [ROW_W-1:0]    cmdRow,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [PAGE_W-1:0]   cmdPage,
  output logic [1:0]          cmdStatus
);

  otbStrobe_t  strobe;
  pageStatus_t lookupStatus;
  pageStatus_t statusInt;
  cmd_t        cmdInt;
  logic        bWrite;

  otb_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .lookupStatus (lookupStatus),
    .bWrite       (bWrite),
    .reqReady     (reqReady),
    .strobe       (strobe),
    .cmdValid     (cmdValid),
    .cmdType      (cmdInt),
    .cmdStatus    (statusInt)
  );

  otb_datapath #(
    .NUM_ROWS  (NUM_ROWS),
    .MAX_BANKS (MAX_BANKS),
    .PAGE_W    (PAGE_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqRow       (reqRow),
    .reqBank      (reqBank),
    .reqPage      (reqPage),
    .reqWrite     (reqWrite),
    .rowFourBank  (rowFourBank),
    .prechargeAll (prechargeAll),
    .lookupStatus (lookupStatus),
    .bWrite       (bWrite),
    .bRow         (cmdRow),
    .bBank        (cmdBank),
    .bPage        (cmdPage)
  );

  assign cmdType   = cmdInt;
  assign cmdStatus = statusInt;

endmodule

// File: tb/test_open_page_tracker.sv
module test_open_page_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqRow = '0;
  logic [1:0]  reqBank = '0;
  logic [11:0] reqPage = '0;
  logic        reqWrite = 1'b0;
  logic [3:0]  rowFourBank = 4'b1101;
  logic        prechargeAll = 1'b0;
  logic        cmdValid;
  logic [2:0]  cmdType;
  logic [1:0]  cmdRow;
  logic [1:0]  cmdBank;
  logic [11:0] cmdPage;
  logic [1:0]  cmdStatus;

  always #5 clk = ~clk;

  open_page_tracker i_open_page_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRow(reqRow), .reqBank(reqBank), .reqPage(reqPage), .reqWrite(reqWrite),
    .rowFourBank(rowFourBank), .prechargeAll(prechargeAll),
    .cmdValid(cmdValid), .cmdType(cmdType), .cmdRow(cmdRow), .cmdBank(cmdBank),
    .cmdPage(cmdPage), .cmdStatus(cmdStatus)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [1:0]  row;
    logic [1:0]  bank;
    logic [11:0] page;
    logic [1:0]  status;
    string       tag;
  } expCmd_t;

  expCmd_t expQ[$];
  int      accStamp[$];
  int      total = 0;
  int      bad = 0;
  int      cycle = 0;
  logic        modValid [16];
  logic [11:0] modPage  [16];

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every issued command with the scoreboard
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected command", int'(cmdType), 0);
      end else begin
        expCmd_t e;
        e = expQ.pop_front();
        check(cmdType == e.kind, {e.tag, " type"}, int'(cmdType), int'(e.kind));
        check({cmdRow, cmdBank, cmdPage} == {e.row, e.bank, e.page}, {e.tag, " R5 addr"},
              int'({cmdRow, cmdBank, cmdPage}), int'({e.row, e.bank, e.page}));
        check(cmdStatus == e.status, {e.tag, " status"}, int'(cmdStatus), int'(e.status));
        if (cmdType == 3'd3 || cmdType == 3'd4) accStamp.push_back(cycle);
      end
    end
  end

  task automatic push(input logic [2:0] k, input logic [1:0] r, input logic [1:0] b,
                      input logic [11:0] p, input logic [1:0] s, input string tag);
    expCmd_t e;
    e.kind = k; e.row = r; e.bank = b; e.page = p; e.status = s; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic send(input logic [1:0] r, input logic [1:0] b, input logic [11:0] p,
                      input logic w, input string tag, output bit stalled);
    logic [1:0] be;
    int idx;
    string t;
    be  = rowFourBank[r] ? b : (b & 2'b01);
    idx = {r, be};
    if (!modValid[idx]) begin
      t = {"R2 ", tag};
      push(3'd2, r, be, p, 2'd0, t);
      push(w ? 3'd4 : 3'd3, r, be, p, 2'd0, t);
    end else if (modPage[idx] == p) begin
      t = {"R3 ", tag};
      push(w ? 3'd4 : 3'd3, r, be, p, 2'd1, t);
    end else begin
      t = {"R4 ", tag};
      push(3'd1, r, be, p, 2'd2, t);
      push(3'd2, r, be, p, 2'd2, t);
      push(w ? 3'd4 : 3'd3, r, be, p, 2'd2, t);
    end
    modValid[idx] = 1'b1;
    modPage[idx]  = p;
    @(negedge clk);
    reqValid = 1'b1; reqRow = r; reqBank = b; reqPage = p; reqWrite = w;
    #1;
    stalled = !reqReady;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cycle, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit st;
    for (int i = 0; i < 16; i++) begin modValid[i] = 1'b0; modPage[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdValid == 1'b0, "R1 cmdValid", int'(cmdValid), 0);
    check(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);

    // empty, hit (write), then miss right behind
    send(2'd0, 2'd0, 12'h010, 1'b0, "R5 first", st);
    send(2'd0, 2'd0, 12'h010, 1'b1, "R5 write hit", st);
    send(2'd0, 2'd0, 12'h022, 1'b0, "R10 miss behind act", st);
    waitIdle();

    // open every entry, then revisit all: pages stay open
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++)
        send(2'(r), 2'(b), 12'(12'h100 + r * 16 + b), 1'(b), "R7 fill", st);
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 4; b++)
        send(2'(r), 2'(b), 12'(12'h100 + r * 16 + b), 1'b0, "R6 revisit", st);
    waitIdle();

    // back-to-back hits give accesses on consecutive cycles
    accStamp.delete();
    for (int b = 0; b < 4; b++)
      send(2'd2, 2'(b), 12'(12'h100 + 32 + b), 1'b0, "R10 burst", st);
    waitIdle();
    check(accStamp.size() == 4, "R10 burst count", accStamp.size(), 4);
    for (int i = 1; i < accStamp.size(); i++)
      check(accStamp[i] - accStamp[i-1] == 1, "R10 burst gap",
            accStamp[i] - accStamp[i-1], 1);

    // same bank, new page immediately after an activate
    send(2'd3, 2'd1, 12'h040, 1'b0, "R10 a", st);
    send(2'd3, 2'd1, 12'h041, 1'b1, "R10 b", st);
    waitIdle();

    // stall while a miss sequence runs
    send(2'd0, 2'd2, 12'h055, 1'b0, "R11 m", st);
    send(2'd0, 2'd3, 12'h056, 1'b0, "R11 x", st);
    send(2'd0, 2'd1, 12'h101, 1'b0, "R11 y", st);
    check(st == 1'b1, "R11 reqReady low", int'(!st), 0);
    waitIdle();

    // two-bank row: bank bit 1 ignored
    send(2'd1, 2'd3, 12'h077, 1'b0, "R8 alias a", st);
    send(2'd1, 2'd1, 12'h077, 1'b1, "R8 alias b", st);
    send(2'd1, 2'd2, 12'h078, 1'b0, "R8 alias c", st);
    waitIdle();

    // precharge-all empties the table
    @(negedge clk);
    prechargeAll = 1'b1;
    @(negedge clk);
    prechargeAll = 1'b0;
    for (int i = 0; i < 16; i++) modValid[i] = 1'b0;
    send(2'd0, 2'd0, 12'h022, 1'b0, "R9 after clear", st);
    send(2'd2, 2'd2, 12'h122, 1'b0, "R9 after clear", st);
    waitIdle();

    check(expQ.size() == 0, "R5 pending commands", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule